// File: doc/BRIEF.md
# ATM Cell Boundary Finder

This block watches a byte-wide receive stream taken from the payload of a framed T1 or E1 line and finds where ATM cells begin. For each byte it checks whether that byte is the correct header check value for the four bytes before it. A header check value is a CRC-8 over the four header bytes, XORed with 0x55. Once it has found a cell boundary, the block counts bytes through each 53-byte cell. It then checks the header only at the header-check position of each cell.

A three-state tracker decides how far the boundary can be trusted. The states are searching, tentative and locked. Two shared configuration inputs set how many good headers confirm a tentative lock (`cfg_confirm`) and how many bad headers in a row break a lock (`cfg_miss`). Typical values are 6 and 7.

While the tracker is searching, the block also counts whole cells' worth of bytes that held no valid header. When that count reaches a programmable threshold, a loss indication rises. The indication stays up until the tracker next reaches the locked state. A single-cycle interrupt pulse marks both the start and the end of loss. A threshold of 360 corresponds to roughly 79 ms on E1 and 100 ms on T1.

Top module: `cell_delin_top`

## Requirements
- R1: After reset the state output reads 0 (searching), and cell_start, loss_status, loss_set_irq and loss_clr_irq are all 0. The state encoding is 0 searching, 1 tentative, 2 locked. The header window is cleared to all-zero bytes.
- R2: While searching, every valid byte is tested. The test compares the byte against CRC-8 (generator x^8+x^2+x+1, initial value 0, bits fed MSB first) taken over the previous four valid bytes, oldest byte first, then XORed with 0x55. A match moves the state to tentative in the next cycle, and that byte is taken as header position 4 of a 53-byte cell (positions 0 to 52).
- R3: In the tentative state, a failed test at header position 4 returns the state to searching.
- R4: In the tentative state, once cfg_confirm consecutive tests at position 4 have passed, the state moves to locked. A setting of 0 acts as 1.
- R5: In the locked state, cfg_miss consecutive failed tests at position 4 return the state to searching, and a passing test restarts the run. A setting of 0 acts as 1.
- R6: When the state is tentative or locked and the byte at position 0 is accepted, cell_start is 1 for exactly the following cycle.
- R7: A cycle with byte_vld low changes no state: the window, byte position, state, run counters and loss count all hold.
- R8: While searching, every 53 consecutive valid bytes without a match add one to the incorrect-cell count. When the count reaches cfg_loss_thr (non-zero), loss_status goes to 1 and loss_set_irq pulses for one cycle. A threshold of 0 never declares loss.
- R9: On entry to the locked state, the incorrect-cell count is cleared. If loss_status was 1, it drops to 0 and loss_clr_irq pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Qualifies byte_in for this cycle |
| byte_in | input | 8 | Received payload byte |
| cfg_miss | input | RUN_W (4) | Bad headers in a row that break a lock |
| cfg_confirm | input | RUN_W (4) | Good headers that confirm a tentative lock |
| cfg_loss_thr | input | THR_W (16) | Incorrect-cell count that declares loss |
| cd_state | output | 2 | 0 searching, 1 tentative, 2 locked |
| cell_start | output | 1 | One-cycle strobe for the first byte of a cell |
| loss_status | output | 1 | Loss of cell delineation is present |
| loss_set_irq | output | 1 | One-cycle pulse on entering loss |
| loss_clr_irq | output | 1 | One-cycle pulse on leaving loss |

## Verification
Every output is registered, so each result of a byte belongs to the cycle right after the clock edge that accepts that byte. This holds for a state change, a cell_start strobe, a loss entry or exit pulse, and the loss level.

The bench drives each byte on a falling edge and advances a reference model of the requirements by that byte. At the next falling edge it compares all five outputs with the model before driving anything new. In this way each result is sampled exactly one register stage after its cause, idle cycles included.

// File: rtl/cd_pkg.sv
package cd_pkg;
    localparam int CELL_BYTES = 53;
    localparam int HEC_IDX    = 4;
    localparam int POS_W      = $clog2(CELL_BYTES);
    localparam logic [7:0] HEC_COSET = 8'h55;
    localparam logic [7:0] HEC_POLY  = 8'h07;

    typedef enum logic [1:0] {
        CD_HUNT    = 2'd0,
        CD_PRESYNC = 2'd1,
        CD_SYNC    = 2'd2
    } cd_state_e;

    // CRC-8, generator x^8+x^2+x+1, zero start, MSB first
    function automatic logic [7:0] hec_crc(input logic [31:0] hdr);
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            fb = c[7] ^ hdr[i];
            c  = {c[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
        end
        return c;
    endfunction
endpackage

// File: rtl/cd_hec_window.sv
module cd_hec_window
    import cd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       hec_ok
);
    typedef struct packed {
        logic [31:0] win;
    } win_s;

    win_s r_q, r_d;

    always_comb begin
        r_d    = r_q;
        hec_ok = byte_vld && ((hec_crc(r_q.win) ^ HEC_COSET) == byte_in);
        if (byte_vld) begin
            r_d.win = {r_q.win[23:0], byte_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R7
    idle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(r_q.win));
endmodule

// File: rtl/cd_sync_fsm.sv
module cd_sync_fsm
    import cd_pkg::*;
#(
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             hec_ok,
    input  logic [RUN_W-1:0] cfg_miss,
    input  logic [RUN_W-1:0] cfg_confirm,
    output logic [1:0]       state_o,
    output logic             cell_start_o,
    output logic             sync_entry_o
);
    typedef struct packed {
        cd_state_e        state;
        logic [POS_W-1:0] pos;
        logic [RUN_W-1:0] run;
        logic             cstart;
    } fsm_s;

    fsm_s r_q, r_d;
    logic [RUN_W:0] run_inc;

    always_comb begin
        r_d          = r_q;
        r_d.cstart   = 1'b0;
        run_inc      = {1'b0, r_q.run} + 1'b1;
        if (byte_vld) begin
            case (r_q.state)
                CD_HUNT: begin
                    if (hec_ok) begin
                        r_d.state = CD_PRESYNC;
                        r_d.pos   = POS_W'(HEC_IDX + 1);
                        r_d.run   = '0;
                    end
                end
                default: begin
                    r_d.cstart = (r_q.pos == '0);
                    r_d.pos    = (r_q.pos == POS_W'(CELL_BYTES - 1)) ? '0 : r_q.pos + 1'b1;
                    if (r_q.pos == POS_W'(HEC_IDX)) begin
                        if (r_q.state == CD_PRESYNC) begin
                            if (!hec_ok) begin
                                r_d.state = CD_HUNT;
                                r_d.run   = '0;
                            end else if (run_inc >= {1'b0, cfg_confirm}) begin
                                r_d.state = CD_SYNC;
                                r_d.run   = '0;
                            end else begin
                                r_d.run = run_inc[RUN_W-1:0];
                            end
                        end else begin
                            if (hec_ok) begin
                                r_d.run = '0;
                            end else if (run_inc >= {1'b0, cfg_miss}) begin
                                r_d.state = CD_HUNT;
                                r_d.run   = '0;
                            end else begin
                                r_d.run = run_inc[RUN_W-1:0];
                            end
                        end
                    end
                end
            endcase
        end
        sync_entry_o = (r_d.state == CD_SYNC) && (r_q.state != CD_SYNC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= CD_HUNT;
            r_q.pos    <= '0;
            r_q.run    <= '0;
            r_q.cstart <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o      = r_q.state;
    assign cell_start_o = r_q.cstart;

    // R4
    sync_from_presync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.state == CD_SYNC) |-> $past(r_q.state) == CD_PRESYNC);
    // R7
    idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(r_q.state) && $stable(r_q.pos) && $stable(r_q.run));
    // R6
    start_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cstart |-> r_q.state != CD_HUNT);
endmodule

// File: rtl/cd_loss_mon.sv
module cd_loss_mon
    import cd_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             in_hunt,
    input  logic             hec_ok,
    input  logic             sync_entry,
    input  logic [THR_W-1:0] cfg_thr,
    output logic             status_o,
    output logic             set_o,
    output logic             clr_o
);
    typedef struct packed {
        logic [POS_W-1:0] hb;
        logic [THR_W-1:0] cnt;
        logic             stat;
        logic             set;
        logic             clr;
    } loss_s;

    loss_s r_q, r_d;
    logic [THR_W-1:0] cnt_up;

    always_comb begin
        r_d     = r_q;
        r_d.set = 1'b0;
        r_d.clr = 1'b0;
        cnt_up  = (&r_q.cnt) ? r_q.cnt : r_q.cnt + 1'b1;
        if (!in_hunt) begin
            r_d.hb = '0;
        end else if (byte_vld) begin
            if (hec_ok) begin
                r_d.hb = '0;
            end else if (r_q.hb == POS_W'(CELL_BYTES - 1)) begin
                r_d.hb  = '0;
                r_d.cnt = cnt_up;
                if ((cfg_thr != '0) && (cnt_up >= cfg_thr) && !r_q.stat) begin
                    r_d.stat = 1'b1;
                    r_d.set  = 1'b1;
                end
            end else begin
                r_d.hb = r_q.hb + 1'b1;
            end
        end
        if (sync_entry) begin
            r_d.cnt = '0;
            if (r_q.stat) begin
                r_d.stat = 1'b0;
                r_d.clr  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status_o = r_q.stat;
    assign set_o    = r_q.set;
    assign clr_o    = r_q.clr;

    // R8
    set_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.set |-> r_q.stat);
    // R8
    status_rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.stat) |-> r_q.set);
    // R9
    clr_drops_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.clr |-> !r_q.stat && $past(r_q.stat));
endmodule

// File: rtl/cell_delin_top.sv
module cell_delin_top
    import cd_pkg::*;
#(
    parameter int RUN_W = 4,
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    input  logic [RUN_W-1:0] cfg_miss,
    input  logic [RUN_W-1:0] cfg_confirm,
    input  logic [THR_W-1:0] cfg_loss_thr,
    output logic [1:0]       cd_state,
    output logic             cell_start,
    output logic             loss_status,
    output logic             loss_set_irq,
    output logic             loss_clr_irq
);
    logic hec_ok;
    logic sync_entry;
    logic in_hunt;

    cd_hec_window win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .hec_ok   (hec_ok)
    );

    cd_sync_fsm #(.RUN_W(RUN_W)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld     (byte_vld),
        .hec_ok       (hec_ok),
        .cfg_miss     (cfg_miss),
        .cfg_confirm  (cfg_confirm),
        .state_o      (cd_state),
        .cell_start_o (cell_start),
        .sync_entry_o (sync_entry)
    );

    assign in_hunt = (cd_state == CD_HUNT);

    cd_loss_mon #(.THR_W(THR_W)) loss_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .in_hunt    (in_hunt),
        .hec_ok     (hec_ok),
        .sync_entry (sync_entry),
        .cfg_thr    (cfg_loss_thr),
        .status_o   (loss_status),
        .set_o      (loss_set_irq),
        .clr_o      (loss_clr_irq)
    );
endmodule

// File: tb/cell_delin_top_tb_top.sv
module cell_delin_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [3:0]  cfg_miss = 4'd7;
    logic [3:0]  cfg_confirm = 4'd6;
    logic [15:0] cfg_loss_thr = 16'd2;
    logic [1:0]  cd_state;
    logic        cell_start, loss_status, loss_set_irq, loss_clr_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit gaps = 1'b0;

    // reference model
    logic [31:0] m_win = '0;
    int m_state = 0, m_pos = 0, m_run = 0, m_hb = 0, m_cnt = 0;
    bit m_stat = 0, e_cs = 0, e_set = 0, e_clr = 0;
    string m_tag = "R1";

    always #2 clk = ~clk;   // 250 MHz

    cell_delin_top dut_i (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .cfg_miss(cfg_miss), .cfg_confirm(cfg_confirm), .cfg_loss_thr(cfg_loss_thr),
        .cd_state(cd_state), .cell_start(cell_start), .loss_status(loss_status),
        .loss_set_irq(loss_set_irq), .loss_clr_irq(loss_clr_irq)
    );

    function automatic logic [7:0] ref_hec(input logic [31:0] h);
        logic [7:0] c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            if (c[7] ^ h[i]) c = {c[6:0], 1'b0} ^ 8'h07;
            else             c = {c[6:0], 1'b0};
        end
        return c ^ 8'h55;
    endfunction

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(m_tag, int'(cd_state), m_state, "state");
        chk("R6", int'(cell_start), int'(e_cs), "cell_start");
        chk("R8", int'(loss_status), int'(m_stat), "loss_status");
        chk("R8", int'(loss_set_irq), int'(e_set), "loss_set_irq");
        chk("R9", int'(loss_clr_irq), int'(e_clr), "loss_clr_irq");
    endtask

    task automatic model(input bit v, input logic [7:0] b);
        int  old;
        bit  ok;
        int  mis, cnf, up;
        old   = m_state;
        ok    = v && (ref_hec(m_win) == b);
        mis   = (cfg_miss == 0) ? 1 : int'(cfg_miss);
        cnf   = (cfg_confirm == 0) ? 1 : int'(cfg_confirm);
        e_cs  = 0; e_set = 0; e_clr = 0;
        m_tag = v ? "R2" : "R7";
        if (old != 0) m_hb = 0;
        if (v) begin
            m_win = {m_win[23:0], b};
            if (old == 0) begin
                if (ok) begin
                    m_state = 1; m_pos = 5; m_run = 0; m_hb = 0;
                end else if (m_hb == 52) begin
                    m_hb = 0;
                    up = (m_cnt == 65535) ? m_cnt : m_cnt + 1;
                    m_cnt = up;
                    if (cfg_loss_thr != 0 && up >= int'(cfg_loss_thr) && !m_stat) begin
                        m_stat = 1; e_set = 1;
                    end
                end else m_hb++;
            end else begin
                m_tag = "R6";
                e_cs  = (m_pos == 0);
                if (m_pos == 4) begin
                    if (old == 1) begin
                        if (!ok) begin m_state = 0; m_run = 0; m_tag = "R3"; end
                        else if (m_run + 1 >= cnf) begin m_state = 2; m_run = 0; m_tag = "R4"; end
                        else begin m_run++; m_tag = "R4"; end
                    end else begin
                        m_tag = "R5";
                        if (ok) m_run = 0;
                        else if (m_run + 1 >= mis) begin m_state = 0; m_run = 0; end
                        else m_run++;
                    end
                end
                m_pos = (m_pos == 52) ? 0 : m_pos + 1;
            end
        end
        if (old != 2 && m_state == 2) begin
            m_cnt = 0;
            if (m_stat) begin m_stat = 0; e_clr = 1; end
        end
    endtask

    task automatic cyc(input bit v, input logic [7:0] b);
        @(negedge clk);
        compare();
        byte_vld = v;
        byte_in  = b;
        model(v, b);
    endtask

    task automatic send_byte(input logic [7:0] b);
        if (gaps && ($urandom % 6 == 0)) cyc(1'b0, 8'($urandom));
        cyc(1'b1, b);
    endtask

    task automatic send_junk(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if (b == ref_hec(m_win)) b ^= 8'h01;
            send_byte(b);
        end
    endtask

    task automatic send_cell(input bit bad);
        logic [31:0] h;
        h = $urandom;
        for (int i = 3; i >= 0; i--) send_byte(h[i*8 +: 8]);
        send_byte(ref_hec(h) ^ (bad ? 8'h01 : 8'h00));
        for (int i = 0; i < 48; i++) send_byte(8'($urandom));
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values checked by the first compare
        cyc(1'b0, 8'h00);
        // R8 loss after two cells' worth of bad hunt bytes
        cfg_loss_thr = 16'd2;
        send_junk(53 * 2 + 7);
        chk("R8", int'(loss_status), 1, "loss after threshold");
        // R2 R4 R9 lock, confirm, clear loss
        for (int i = 0; i < 8; i++) send_cell(1'b0);
        chk("R4", int'(cd_state), 2, "locked after confirm");
        // R5 a run one short of the limit, reset by a good header, then full run
        for (int i = 0; i < 6; i++) send_cell(1'b1);
        send_cell(1'b0);
        chk("R5", int'(cd_state), 2, "still locked");
        for (int i = 0; i < 7; i++) send_cell(1'b1);
        // R3 tentative failure
        send_junk(60);
        send_cell(1'b0); send_cell(1'b0); send_cell(1'b1);
        send_junk(10);
        // R4 R5 zero settings act as one
        cfg_miss = 4'd0; cfg_confirm = 4'd0;
        send_junk(5);
        send_cell(1'b0); send_cell(1'b0); send_cell(1'b1);
        // R7 idle cycles between bytes, randomized configuration
        gaps = 1'b1;
        for (int k = 0; k < 15; k++) begin
            cfg_miss     = 4'($urandom_range(0, 4));
            cfg_confirm  = 4'($urandom_range(0, 4));
            cfg_loss_thr = 16'($urandom_range(0, 3));
            send_junk($urandom_range(0, 120));
            for (int i = 0; i < 20; i++) send_cell(($urandom % 4) == 0);
        end
        cyc(1'b0, 8'h00);
        cyc(1'b0, 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule